// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

This block moves data for a processor without the processor touching each item. It has four channels. Each channel holds a source address, a destination address, a 24-bit transfer count and a control word. A channel runs while its enable bit is set and its request input is high. A shared arbiter chooses which eligible channel gets the memory bus next, using either fixed or rotating priority. The `rr_mode` input selects which.

Each transfer uses one of two modes. In dual-address mode the engine reads the unit from the source address and then writes the captured data to the destination address. In single-address mode the engine issues one bus cycle and raises the channel's acknowledge output during it. The external device on the other side uses that strobe to supply or take the data. A channel either releases the bus after every transfer (cycle steal) or keeps it until its count runs out (burst). When the count runs out, the channel disables itself and may raise an interrupt.

The sequencer is a state machine with six states: IDLE, GRANT, READ, WRITE, SINGLE and NEXT.
- IDLE→GRANT: a channel is eligible. It is accepted and latched.
- GRANT→READ: the channel is in dual mode.
- GRANT→SINGLE: the channel is in single mode.
- READ→WRITE: the read is acknowledged by the bus.
- WRITE→READ: more beats of a block remain.
- WRITE→NEXT and SINGLE→NEXT: the last beat is accepted.
- NEXT→GRANT: a burst channel has transfers left.
- NEXT→IDLE: all other cases.

Top module: `dma_engine`

## Requirements
- R1: After reset there is no bus activity, every acknowledge output is low and every interrupt output is low.
- R2: Control bits [3:1] select the unit: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes and 4 is a 32-byte block. `bus_size` reports the unit code. A block runs as four 8-byte beats at base, base+8, base+16 and base+24, each with `bus_size` 3.
- R3: The count register is 24 bits wide, and a count of 0 means 16,777,216 transfers. After the programmed number of transfers, the channel clears its own enable bit and makes no further bus cycles, even with its request still high.
- R4: Control bit 8 set selects single-address mode. In this mode each unit (each beat for a block) takes one bus cycle with `dack` of that channel high, and no other acknowledge is high. If bit 9 is set, the cycle is a write to the destination address; if bit 9 is clear, it is a read from the source address.
- R5: With bit 8 clear (dual-address mode), each unit is a read at the source address followed by a write at the destination address. The write carries the read data.
- R6: Control bits [5:4] set the source stepping and bits [7:6] set the destination stepping: 0 is fixed, 1 is increment, 2 is decrement. After each transfer the address moves by the unit size in bytes (32 for a block).
- R7: With control bit 10 clear (cycle steal), the bus is re-arbitrated after every transfer.
- R8: With control bit 10 set (burst), the granted channel keeps the bus until its count is exhausted, whatever the other requests are.
- R9: With `rr_mode` low, the lowest-numbered eligible channel always wins.
- R10: With `rr_mode` high, the most recently accepted channel becomes lowest priority. The order after reset is 0, 1, 2, 3.
- R11: On completion, `irq` of the channel goes high if control bit 11 is set and stays high until that channel's control word is written again. If bit 11 is clear, no interrupt is raised.
- R12: A channel whose request is low is never served. While `bus_valid` is high and `bus_ready` is low, the address and direction are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel number for the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Write data |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge for single-address cycles |
| irq | output | 4 | Per-channel completion interrupt |
| bus_valid | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Byte address |
| bus_size | output | 3 | Unit code of the cycle |
| bus_wdata | output | 64 | Write data for dual-address writes |
| bus_rdata | input | 64 | Read data |
| bus_ready | input | 1 | Bus accepts the cycle in this clock |

## Verification
Four properties are checked on every cycle:
- at most one acknowledge is high, and only inside a bus cycle;
- the address and direction hold while the bus stalls;
- the reported size code is legal;
- a channel with a pending interrupt is no longer enabled.

The remaining behaviour can only be shown by the bench's scenarios, which compare every bus cycle against an expected list:
- the order of grants under fixed, rotating and burst ownership;
- address stepping in all three directions;
- block beats;
- the zero-means-maximum count;
- stopping after the final transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam logic [1:0] STEP_FIX = 2'd0;
    localparam logic [1:0] STEP_INC = 2'd1;
    localparam logic [1:0] STEP_DEC = 2'd2;

    localparam logic [2:0] UNIT_D   = 3'd3;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    // control word layout, MSB first: ie, burst, dev_src, single, dst_step, src_step, unit, en
    typedef struct packed {
        logic       ie;
        logic       burst;
        logic       dev_src;
        logic       single;
        logic [1:0] dst_step;
        logic [1:0] src_step;
        logic [2:0] unit;
        logic       en;
    } ctrl_t;

    // the part of the control word the sequencer needs
    typedef struct packed {
        logic       burst;
        logic       dev_src;
        logic       single;
        logic [2:0] unit;
    } mode_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_GRANT  = 3'd1,
        S_READ   = 3'd2,
        S_WRITE  = 3'd3,
        S_SINGLE = 3'd4,
        S_NEXT   = 3'd5
    } state_e;

    function automatic logic [5:0] unit_bytes(input logic [2:0] u);
        if (u[2])
            return 6'd32;
        return 6'(6'd1 << u[1:0]);
    endfunction

endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rr_mode,
    input  logic                 accept,
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [$clog2(N)-1:0] gnt
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] last_q;

    always_comb begin
        logic found;
        int   base;
        found = 1'b0;
        gnt   = '0;
        any   = |req;
        base  = rr_mode ? int'(last_q) + 1 : 0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (base + k) % N;
            if (!found && req[idx]) begin
                gnt   = IW'(idx);
                found = 1'b1;
            end
        end
    end

    // rotating pointer: the last accepted channel goes to the back
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IW'(N - 1);
        else if (accept && rr_mode)
            last_q <= gnt;
    end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          step,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output mode_t         mode,
    output logic          en,
    output logic          ie,
    output logic          last,
    output logic          irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t         ctrl;
    logic [CW-1:0] cnt;
    logic          done;
    logic [5:0]    nbytes;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] a,
                                              input logic [1:0]    how,
                                              input logic [5:0]    b);
        case (how)
            STEP_INC: return a + AW'(b);
            STEP_DEC: return a - AW'(b);
            default:  return a;
        endcase
    endfunction

    assign nbytes = unit_bytes(ctrl.unit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            ctrl <= '0;
            done <= 1'b0;
        end else begin
            if (step) begin
                src <= advance(src, ctrl.src_step, nbytes);
                dst <= advance(dst, ctrl.dst_step, nbytes);
                cnt <= cnt - 1'b1;          // 0 wraps: counts 2**CW transfers
                if (last) begin
                    ctrl.en <= 1'b0;
                    done    <= 1'b1;
                end
            end
            if (wr_en) begin
                unique case (sel_e'(wr_sel))
                    SEL_SRC:  src <= wr_data;
                    SEL_DST:  dst <= wr_data;
                    SEL_CNT:  cnt <= wr_data[CW-1:0];
                    SEL_CTRL: begin
                        ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
                        done <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign last = (cnt == CW'(1));
    assign irq  = done & ctrl.ie;
    assign en   = ctrl.en;
    assign ie   = ctrl.ie;
    assign mode = '{burst: ctrl.burst, dev_src: ctrl.dev_src,
                    single: ctrl.single, unit: ctrl.unit};

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 any,
    input  logic [$clog2(N)-1:0] gnt,
    input  mode_t                cur_mode,
    input  logic [AW-1:0]        cur_src,
    input  logic [AW-1:0]        cur_dst,
    input  logic                 cur_last,
    input  logic                 bus_ready,
    input  logic [DW-1:0]        bus_rdata,
    output logic                 accept,
    output logic                 step,
    output logic [$clog2(N)-1:0] cur_ch,
    output logic                 bus_valid,
    output logic                 bus_we,
    output logic [AW-1:0]        bus_addr,
    output logic [2:0]           bus_size,
    output logic [DW-1:0]        bus_wdata,
    output logic [N-1:0]         ack
);
    localparam int BEAT_BYTES = DW / 8;
    localparam int BEAT_SH    = $clog2(BEAT_BYTES);
    localparam int BLK_BEATS  = 32 / BEAT_BYTES;
    localparam int BW         = (BLK_BEATS > 1) ? $clog2(BLK_BEATS) : 1;

    state_e        state, nstate;
    logic [BW-1:0] beat;
    logic [DW-1:0] hold;
    logic          blk;
    logic          beat_last;
    logic [AW-1:0] offs;

    assign blk       = cur_mode.unit[2];
    assign beat_last = !blk || (beat == BW'(BLK_BEATS - 1));
    assign offs      = blk ? (AW'(beat) << BEAT_SH) : '0;

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (any) nstate = S_GRANT;
            S_GRANT:  nstate = cur_mode.single ? S_SINGLE : S_READ;
            S_READ:   if (bus_ready) nstate = S_WRITE;
            S_WRITE:  if (bus_ready) nstate = beat_last ? S_NEXT : S_READ;
            S_SINGLE: if (bus_ready && beat_last) nstate = S_NEXT;
            S_NEXT:   nstate = (cur_mode.burst && !cur_last) ? S_GRANT : S_IDLE;
            default:  nstate = S_IDLE;
        endcase
    end

    // state register and sequencing datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cur_ch <= '0;
            beat   <= '0;
            hold   <= '0;
        end else begin
            state <= nstate;
            if (state == S_IDLE && any)
                cur_ch <= gnt;
            if (state == S_READ && bus_ready)
                hold <= bus_rdata;
            if (state == S_GRANT || state == S_NEXT)
                beat <= '0;
            else if (bus_ready && (state == S_WRITE || state == S_SINGLE) && !beat_last)
                beat <= beat + 1'b1;
        end
    end

    // outputs
    always_comb begin
        accept    = (state == S_IDLE) && any;
        step      = (state == S_NEXT);
        bus_valid = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        ack       = '0;
        bus_size  = blk ? UNIT_D : cur_mode.unit;
        unique case (state)
            S_READ: begin
                bus_valid = 1'b1;
                bus_addr  = cur_src + offs;
            end
            S_WRITE: begin
                bus_valid = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = cur_dst + offs;
                bus_wdata = hold;
            end
            S_SINGLE: begin
                bus_valid   = 1'b1;
                bus_we      = cur_mode.dev_src;
                bus_addr    = (cur_mode.dev_src ? cur_dst : cur_src) + offs;
                ack[cur_ch] = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 64,
    parameter int CW  = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rr_mode,
    input  logic                   cfg_we,
    input  logic [$clog2(NCH)-1:0] cfg_ch,
    input  logic [1:0]             cfg_sel,
    input  logic [AW-1:0]          cfg_wdata,
    input  logic [NCH-1:0]         dreq,
    output logic [NCH-1:0]         dack,
    output logic [NCH-1:0]         irq,
    output logic                   bus_valid,
    output logic                   bus_we,
    output logic [AW-1:0]          bus_addr,
    output logic [2:0]             bus_size,
    output logic [DW-1:0]          bus_wdata,
    input  logic [DW-1:0]          bus_rdata,
    input  logic                   bus_ready
);
    localparam int IW = $clog2(NCH);

    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    mode_t          mode_a[NCH];
    logic [NCH-1:0] en_v;
    logic [NCH-1:0] ie_v;
    logic [NCH-1:0] last_v;
    logic [NCH-1:0] elig;

    logic           any, accept, step;
    logic [IW-1:0]  gnt, cur_ch;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_ch == IW'(g))),
            .wr_sel  (cfg_sel),
            .wr_data (cfg_wdata),
            .step    (step && (cur_ch == IW'(g))),
            .src     (src_a[g]),
            .dst     (dst_a[g]),
            .mode    (mode_a[g]),
            .en      (en_v[g]),
            .ie      (ie_v[g]),
            .last    (last_v[g]),
            .irq     (irq[g])
        );
        assign elig[g] = en_v[g] & dreq[g];
    end

    dma_arb #(.N(NCH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rr_mode (rr_mode),
        .accept  (accept),
        .req     (elig),
        .any     (any),
        .gnt     (gnt)
    );

    dma_seq #(.N(NCH), .AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any       (any),
        .gnt       (gnt),
        .cur_mode  (mode_a[cur_ch]),
        .cur_src   (src_a[cur_ch]),
        .cur_dst   (dst_a[cur_ch]),
        .cur_last  (last_v[cur_ch]),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .accept    (accept),
        .step      (step),
        .cur_ch    (cur_ch),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .ack       (dack)
    );

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int NCH = 4,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] dack,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] en_v,
    input logic           bus_valid,
    input logic           bus_ready,
    input logic           bus_we,
    input logic [AW-1:0]  bus_addr,
    input logic [2:0]     bus_size
);

    p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack))
        else $error("more than one acknowledge high");

    p_ack_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> bus_valid)
        else $error("acknowledge outside a bus cycle");

    p_hold_on_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)))
        else $error("bus cycle changed while stalled");

    p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_size <= 3'd3))
        else $error("illegal size code on bus");

    p_done_disables_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & en_v) == '0)
        else $error("interrupting channel still enabled");

endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dack      (dack),
    .irq       (irq),
    .en_v      (en_v),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size)
);

// File: tb/tb_dma_engine.sv
module tb_dma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rr_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack, irq;
    logic        bus_valid, bus_we, bus_ready;
    logic [31:0] bus_addr;
    logic [2:0]  bus_size;
    logic [63:0] bus_wdata, bus_rdata;
    logic        gate = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // slave: accepts every other cycle, read data derived from the address
    always @(posedge clk) gate <= ~gate;
    assign bus_ready = bus_valid & gate;

    function automatic logic [63:0] memv(input logic [31:0] a);
        return {~a, a};
    endfunction
    assign bus_rdata = memv(bus_addr);

    dma_engine dut (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dreq(dreq), .dack(dack), .irq(irq),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [2:0]  size;
        logic [63:0] data;
        logic        chk_data;
        logic [3:0]  ack;
        string       req;
    } op_t;

    op_t q[$];
    int  n_chk = 0;
    int  n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: every accepted bus cycle must match the head of the queue
    always @(negedge clk) begin
        op_t e;
        if (rst_n && bus_valid && bus_ready) begin
            if (q.size() == 0) begin
                check(1'b0, "R3/R12", "unexpected bus cycle at", {32'd0, bus_addr}, 64'd0);
            end else begin
                e = q.pop_front();
                check(bus_we == e.we && bus_addr == e.addr && bus_size == e.size &&
                      dack == e.ack && (!e.chk_data || bus_wdata == e.data),
                      e.req, "bus cycle {we,size,ack,addr}",
                      {27'd0, bus_we, bus_size, dack, bus_addr},
                      {27'd0, e.we, e.size, e.ack, e.addr});
            end
        end
    end

    // ---------------- driver helpers ----------------
    function automatic logic [31:0] mk_ctrl(input int unit, input int ss, input int ds,
                                            input bit single, input bit devsrc,
                                            input bit burst, input bit ie);
        logic [31:0] c;
        c = '0;
        c[0]   = 1'b1;
        c[3:1] = 3'(unit);
        c[5:4] = 2'(ss);
        c[7:6] = 2'(ds);
        c[8]   = single;
        c[9]   = devsrc;
        c[10]  = burst;
        c[11]  = ie;
        return c;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] a, input int how, input int unit);
        int b;
        b = (unit == 4) ? 32 : (1 << unit);
        if (how == 1) return a + 32'(b);
        if (how == 2) return a - 32'(b);
        return a;
    endfunction

    task automatic cfg(input int ch, input int sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] n, input logic [31:0] c);
        cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, n); cfg(ch, 3, c);
    endtask

    task automatic push_op(input bit we, input logic [31:0] a, input int sz,
                           input logic [63:0] d, input bit cd, input logic [3:0] ack,
                           input string req);
        op_t e;
        e.we = we; e.addr = a; e.size = 3'(sz); e.data = d;
        e.chk_data = cd; e.ack = ack; e.req = req;
        q.push_back(e);
    endtask

    // one dual-address unit: read(s) then write(s)
    task automatic push_dual(input logic [31:0] s, input logic [31:0] d,
                             input int unit, input string req);
        if (unit == 4) begin
            for (int b = 0; b < 4; b++) begin
                push_op(1'b0, s + 32'(8*b), 3, 64'd0, 1'b0, 4'b0, req);
                push_op(1'b1, d + 32'(8*b), 3, memv(s + 32'(8*b)), 1'b1, 4'b0, req);
            end
        end else begin
            push_op(1'b0, s, unit, 64'd0, 1'b0, 4'b0, req);
            push_op(1'b1, d, unit, memv(s), 1'b1, 4'b0, req);
        end
    endtask

    task automatic wait_drain();
        int t;
        t = 0;
        while (q.size() != 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 5000) check(1'b0, "R12", "expected cycles missing, left", 64'(q.size()), 64'd0);
        repeat (16) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dreq = '0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog", "run did not finish, cycles", 64'd150000, 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] s, d;
        int          nw;

        do_reset();
        // R1: reset state
        check(bus_valid == 1'b0, "R1", "bus_valid after reset", 64'(bus_valid), 64'd0);
        check(dack == 4'b0, "R1", "dack after reset", 64'(dack), 64'd0);
        check(irq == 4'b0, "R1", "irq after reset", 64'(irq), 64'd0);

        // R5 R6 R11 R3: dual, 4-byte, inc/inc, count 3, request kept high
        s = 32'h1000; d = 32'h2000;
        for (int i = 0; i < 3; i++) begin
            push_dual(s, d, 2, "R5");
            s = nxt(s, 1, 2); d = nxt(d, 1, 2);
        end
        setup(0, 32'h1000, 32'h2000, 3, mk_ctrl(2, 1, 1, 0, 0, 0, 1));
        dreq[0] = 1'b1;
        wait_drain();
        check(irq[0] == 1'b1, "R11", "irq after completion", 64'(irq), 64'd1);
        dreq[0] = 1'b0;
        cfg(0, 3, 32'd0);
        @(negedge clk);
        check(irq[0] == 1'b0, "R11", "irq after control rewrite", 64'(irq), 64'd0);

        // R6: decrement source, fixed destination, bytes, interrupt off
        push_dual(32'h3010, 32'h4000, 0, "R6");
        push_dual(32'h300F, 32'h4000, 0, "R6");
        setup(1, 32'h3010, 32'h4000, 2, mk_ctrl(0, 2, 0, 0, 0, 0, 0));
        dreq[1] = 1'b1;
        wait_drain();
        dreq[1] = 1'b0;
        check(irq == 4'b0, "R11", "irq with interrupt disabled", 64'(irq), 64'd0);

        // R4: single address, device is source -> writes to destination
        push_op(1'b1, 32'h5000, 1, 64'd0, 1'b0, 4'b0100, "R4");
        push_op(1'b1, 32'h5002, 1, 64'd0, 1'b0, 4'b0100, "R4");
        setup(2, 32'h0, 32'h5000, 2, mk_ctrl(1, 0, 1, 1, 1, 0, 0));
        dreq[2] = 1'b1;
        wait_drain();
        dreq[2] = 1'b0;
        // R4: single address, device is destination -> read from source
        push_op(1'b0, 32'h6000, 3, 64'd0, 1'b0, 4'b1000, "R4");
        setup(3, 32'h6000, 32'h0, 1, mk_ctrl(3, 1, 0, 1, 0, 0, 0));
        dreq[3] = 1'b1;
        wait_drain();
        dreq[3] = 1'b0;

        // R2: 32-byte blocks, source inc, destination dec
        push_dual(32'h7000, 32'h8000, 4, "R2");
        push_dual(32'h7020, 32'h7FE0, 4, "R2");
        setup(0, 32'h7000, 32'h8000, 2, mk_ctrl(4, 1, 2, 0, 0, 0, 0));
        dreq[0] = 1'b1;
        wait_drain();
        dreq[0] = 1'b0;

        // R9 R7: fixed priority, cycle steal
        do_reset();
        rr_mode = 1'b0;
        for (int c = 0; c < 3; c++) begin
            push_dual(32'hA000 + 32'(c*256), 32'hB000 + 32'(c*256), 2, "R9");
            push_dual(32'hA004 + 32'(c*256), 32'hB004 + 32'(c*256), 2, "R9");
        end
        for (int c = 0; c < 3; c++)
            setup(c, 32'hA000 + 32'(c*256), 32'hB000 + 32'(c*256), 2, mk_ctrl(2, 1, 1, 0, 0, 0, 0));
        dreq = 4'b0111;
        wait_drain();
        dreq = '0;

        // R10 R7: rotating priority, order 0,1,2 repeated
        do_reset();
        rr_mode = 1'b1;
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 3; c++)
                push_dual(32'hA000 + 32'(c*256 + r*4), 32'hB000 + 32'(c*256 + r*4), 2, "R10");
        for (int c = 0; c < 3; c++)
            setup(c, 32'hA000 + 32'(c*256), 32'hB000 + 32'(c*256), 2, mk_ctrl(2, 1, 1, 0, 0, 0, 0));
        dreq = 4'b0111;
        wait_drain();
        dreq = '0;

        // R8: burst channel 0 holds the bus under rotating priority
        do_reset();
        rr_mode = 1'b1;
        for (int i = 0; i < 3; i++) push_dual(32'hC000 + 32'(i*2), 32'hD000 + 32'(i*2), 1, "R8");
        for (int i = 0; i < 2; i++) push_dual(32'hC100 + 32'(i*2), 32'hD100 + 32'(i*2), 1, "R8");
        setup(0, 32'hC000, 32'hD000, 3, mk_ctrl(1, 1, 1, 0, 0, 1, 0));
        setup(1, 32'hC100, 32'hD100, 2, mk_ctrl(1, 1, 1, 0, 0, 0, 0));
        dreq = 4'b0011;
        wait_drain();
        dreq = '0;
        rr_mode = 1'b0;

        // R12: enabled channel without request is never served
        setup(3, 32'hE000, 32'hE100, 1, mk_ctrl(2, 1, 1, 0, 0, 0, 1));
        repeat (30) @(negedge clk);
        check(bus_valid == 1'b0, "R12", "bus idle without request", 64'(bus_valid), 64'd0);
        check(irq[3] == 1'b0, "R12", "no completion without request", 64'(irq), 64'd0);
        cfg(3, 3, 32'd0);

        // R3: count 0 is the maximum, not a single transfer
        for (int i = 0; i < 5; i++) push_dual(32'hF000 + 32'(i), 32'hF800 + 32'(i), 0, "R3");
        setup(0, 32'hF000, 32'hF800, 0, mk_ctrl(0, 1, 1, 0, 0, 0, 1));
        dreq[0] = 1'b1;
        nw = 0;
        while (nw < 5) begin
            @(negedge clk);
            if (bus_valid && bus_ready && bus_we) nw++;
        end
        dreq[0] = 1'b0;
        wait_drain();
        check(irq[0] == 1'b0, "R3", "zero count not finished after 5", 64'(irq), 64'd0);
        cfg(0, 3, 32'd0);
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule